// File: doc/BRIEF.md
# Cascaded Prescaler Square-Wave Generator

This block turns a fast system clock into a 50% duty square wave at one of ten preset low frequencies, from 0.01 Hz up to 100 Hz. The division needed at the slowest setting is far beyond what one 16-bit counter can count. So the division is split across two chained counter stages. A prescaler stage feeds a period stage, and a toggle state machine at the end flips the output once per half period. Each stage hands its carry to the next as a strobe. That strobe is re-registered on the system clock, so no combinational path runs through the chain.

A 4-bit code on `sel_i` picks the frequency. The divisor pair for every code is computed when the design is elaborated, from the clock-frequency parameter and the stage width. A new code takes effect only at the next output edge. At that edge every counter reloads, so no half period is ever cut short. `en_i` freezes the whole chain while it is low. `tc_o` marks the first cycle of every new half period.

The toggle state machine has three states:
- `ST_IDLE`: the state after reset. The output is low.
- `ST_LOW`: the output is low.
- `ST_HIGH`: the output is high.

It moves through them as follows:
- `ST_IDLE` to `ST_LOW`: on the first enabled cycle. This transition loads the counters.
- `ST_LOW` to `ST_HIGH`: on an enabled cycle with a period-stage strobe. This transition reloads the counters.
- `ST_HIGH` to `ST_LOW`: on an enabled cycle with a period-stage strobe. This transition reloads the counters.

Top module: `sqgen_top`

## Requirements
- R1: While `rst_ni` is low, `sq_o` and `tc_o` are 0 and the machine is in `ST_IDLE`. The reset is asynchronous.
- R2: Codes 0 to 9 on `sel_i` select, in order, 0.01, 0.1, 0.2, 0.5, 1, 2, 5, 10, 50 and 100 Hz. Codes 10 to 15 behave exactly like code 9.
- R3: For a selected frequency whose value in hundredths of a hertz is F, the chain count is H = CLK_HZ*50/F - 2. The prescaler divisor is P = ceil(H / 2^STAGE_W) and the period divisor is Q = floor(H / P). Each half period, high or low, lasts P*Q+2 enabled clock cycles, so the high and low halves are equal.
- R4: `tc_o` is 1 for exactly the first cycle after each edge of `sq_o`, and is 0 at all other times.
- R5: The first enabled cycle after reset loads the counters without raising `tc_o`. `sq_o` then stays low for one full half period of the selected frequency.
- R6: A change of `sel_i` during a half period does not alter that half period. The new code is captured at the next edge of `sq_o` and governs the half periods that follow it.
- R7: While `en_i` is low, `sq_o` and all counters hold their values and `tc_o` is 0. Each half period is lengthened by exactly the number of disabled cycles.
- R8: Every preset's P-1 and Q-1 fit in STAGE_W bits, and H is at least 1. A checker reports any selectable code that breaks this.
- R9: Dropping `rst_ni` in the middle of a half period returns the block to the R1 state at once. The next enabled cycle starts afresh as in R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low freezes the chain and output |
| sel_i | input | 4 | Frequency preset code |
| sq_o | output | 1 | Square-wave output |
| tc_o | output | 1 | One-cycle strobe at the start of each half period |

## Verification
The hardest case to reach is the slowest preset. At a real clock rate, both chained stages must run close to their full range before the output moves at all, which would take far too long to reach from the ports. The bench therefore builds the block with a 1000 Hz clock parameter and 8-bit stages. At that size the 0.01 Hz preset needs a prescaler of 196 and a period count of 255, so both stages still carry at nearly full width within about fifty thousand cycles. Select changes are driven on the very cycle after an output edge, where a premature capture would show at once. Enable is also chopped in irregular patterns inside half periods, so any counter that slips while frozen shifts the next edge.

// File: rtl/sqgen_pkg.sv
`timescale 1ns/1ps
package sqgen_pkg;

    localparam int NUM_PRESETS = 10;
    localparam int SEL_W       = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } sq_state_e;

    // Preset frequency in hundredths of a hertz; codes above the last preset
    // fold onto it.
    function automatic longint centi_hz(int code);
        case ((code >= NUM_PRESETS) ? NUM_PRESETS - 1 : code)
            0:       return 64'd1;
            1:       return 64'd10;
            2:       return 64'd20;
            3:       return 64'd50;
            4:       return 64'd100;
            5:       return 64'd200;
            6:       return 64'd500;
            7:       return 64'd1000;
            8:       return 64'd5000;
            default: return 64'd10000;
        endcase
    endfunction

    // Cycles the two stages must span per half period (two cycles of strobe
    // pipeline are added back by the chain itself).
    function automatic longint chain_count(longint clk_hz, int code);
        return (clk_hz * 64'd50) / centi_hz(code) - 64'd2;
    endfunction

    function automatic longint pre_count(longint clk_hz, int w, int code);
        longint cap;
        cap = longint'(1) <<< w;
        return (chain_count(clk_hz, code) + cap - 64'd1) / cap;
    endfunction

    function automatic longint per_count(longint clk_hz, int w, int code);
        return chain_count(clk_hz, code) / pre_count(clk_hz, w, code);
    endfunction

endpackage

// File: rtl/sqgen_stage.sv
`timescale 1ns/1ps
// One down-counting divider stage. Counts on enabled cycles, reloads from the
// value captured at the last load, and registers its carry strobe.
module sqgen_stage #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         run_i,
    input  logic         cnt_en_i,
    input  logic         load_i,
    input  logic [W-1:0] reload_i,
    output logic         stb_o
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] keep_q;
    logic         stb_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            keep_q <= '0;
            stb_q  <= 1'b0;
        end else if (run_i) begin
            if (load_i) begin
                cnt_q  <= reload_i;
                keep_q <= reload_i;
                stb_q  <= 1'b0;
            end else if (cnt_en_i) begin
                if (cnt_q == '0) begin
                    cnt_q <= keep_q;
                    stb_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - W'(1);
                    stb_q <= 1'b0;
                end
            end else begin
                stb_q <= 1'b0;
            end
        end
    end

    assign stb_o = stb_q;

endmodule

// File: rtl/sqgen_divtab.sv
`timescale 1ns/1ps
// Per-code reload values (divisor minus one), computed at elaboration.
module sqgen_divtab
    import sqgen_pkg::*;
#(
    parameter longint CLK_HZ  = 48_000_000,
    parameter int     STAGE_W = 16
) (
    input  logic [SEL_W-1:0]   sel_i,
    output logic [STAGE_W-1:0] pre_o,
    output logic [STAGE_W-1:0] per_o
);

    localparam int NCODES = 1 << SEL_W;

    logic [STAGE_W-1:0] pre_tab [NCODES];
    logic [STAGE_W-1:0] per_tab [NCODES];

    for (genvar g = 0; g < NCODES; g++) begin : g_code
        assign pre_tab[g] = STAGE_W'(pre_count(CLK_HZ, STAGE_W, g) - 64'd1);
        assign per_tab[g] = STAGE_W'(per_count(CLK_HZ, STAGE_W, g) - 64'd1);
    end

    assign pre_o = pre_tab[sel_i];
    assign per_o = per_tab[sel_i];

endmodule

// File: rtl/sqgen_toggle.sv
`timescale 1ns/1ps
// Final stage: half-period state machine giving the 50% duty output.
module sqgen_toggle
    import sqgen_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic stb_i,
    output logic load_o,
    output logic sq_o,
    output logic tc_o
);

    sq_state_e state_q, state_d;
    logic      tc_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (run_i)          state_d = ST_LOW;
            ST_LOW:  if (run_i && stb_i) state_d = ST_HIGH;
            ST_HIGH: if (run_i && stb_i) state_d = ST_LOW;
            default:                     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tc_q <= 1'b0;
        end else begin
            tc_q <= run_i && stb_i && (state_q != ST_IDLE);
        end
    end

    assign load_o = run_i && ((state_q == ST_IDLE) || stb_i);
    assign sq_o   = (state_q == ST_HIGH);
    assign tc_o   = tc_q;

endmodule

// File: rtl/sqgen_top.sv
`timescale 1ns/1ps
module sqgen_top
    import sqgen_pkg::*;
#(
    parameter longint CLK_HZ  = 48_000_000,
    parameter int     STAGE_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             sq_o,
    output logic             tc_o
);

    localparam int NSTG = 2;

    logic [STAGE_W-1:0] ld_val [NSTG];
    logic [NSTG:0]      stb_chain;
    logic               load;

    assign stb_chain[0] = 1'b1;

    sqgen_divtab #(
        .CLK_HZ  (CLK_HZ),
        .STAGE_W (STAGE_W)
    ) u_tab (
        .sel_i (sel_i),
        .pre_o (ld_val[0]),
        .per_o (ld_val[1])
    );

    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        sqgen_stage #(
            .W (STAGE_W)
        ) u_stage (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .run_i    (en_i),
            .cnt_en_i (stb_chain[g]),
            .load_i   (load),
            .reload_i (ld_val[g]),
            .stb_o    (stb_chain[g+1])
        );
    end

    sqgen_toggle u_fsm (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (en_i),
        .stb_i  (stb_chain[NSTG]),
        .load_o (load),
        .sq_o   (sq_o),
        .tc_o   (tc_o)
    );

endmodule

// File: rtl/sqgen_checker.sv
`timescale 1ns/1ps
module sqgen_checker
    import sqgen_pkg::*;
#(
    parameter longint CLK_HZ  = 48_000_000,
    parameter int     STAGE_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             en_i,
    input logic [SEL_W-1:0] sel_i,
    input logic             sq_o,
    input logic             tc_o
);

    localparam longint LIMIT = longint'(1) <<< STAGE_W;

    assert_div_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (chain_count(CLK_HZ, int'(sel_i)) >= 64'd1) &&
        (pre_count(CLK_HZ, STAGE_W, int'(sel_i)) <= LIMIT) &&
        (per_count(CLK_HZ, STAGE_W, int'(sel_i)) <= LIMIT));

    assert_tc_marks_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tc_o |-> (sq_o != $past(sq_o)));

    assert_edge_has_tc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sq_o != $past(sq_o)) |-> tc_o);

    assert_tc_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tc_o |=> !tc_o);

    assert_hold_when_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> ($stable(sq_o) && !tc_o));

    assert_reset_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (!sq_o && !tc_o));

endmodule

bind sqgen_top sqgen_checker #(
    .CLK_HZ  (CLK_HZ),
    .STAGE_W (STAGE_W)
) u_check (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .sel_i  (sel_i),
    .sq_o   (sq_o),
    .tc_o   (tc_o)
);

// File: tb/test_sqgen_top.sv
`timescale 1ns/1ps
module test_sqgen_top;

    localparam longint CLK_HZ  = 1000;
    localparam int     STAGE_W = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [3:0] sel = 4'd0;
    logic       sq;
    logic       tc;

    int    checks = 0;
    int    failures = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference model state
    bit m_idle = 1'b1;
    bit m_out  = 1'b0;
    bit m_tc   = 1'b0;
    int m_rem  = 0;

    always #2 clk = ~clk;

    sqgen_top #(
        .CLK_HZ  (CLK_HZ),
        .STAGE_W (STAGE_W)
    ) i_sqgen_top (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .en_i   (en),
        .sel_i  (sel),
        .sq_o   (sq),
        .tc_o   (tc)
    );

    // Half-period length from R2/R3.
    function automatic int half_len(logic [3:0] s);
        int     chz [10] = '{1, 10, 20, 50, 100, 200, 500, 1000, 5000, 10000};
        int     idx = (s > 4'd9) ? 9 : int'(s);
        longint cap = longint'(1) <<< STAGE_W;
        longint h = CLK_HZ * 50 / chz[idx] - 2;
        longint p = (h + cap - 1) / cap;
        longint q = h / p;
        return int'(p * q + 2);
    endfunction

    function automatic void check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Behavioural model: a count of enabled cycles left in the half period.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_idle <= 1'b1;
            m_out  <= 1'b0;
            m_tc   <= 1'b0;
            m_rem  <= 0;
        end else if (en) begin
            if (m_idle) begin
                m_idle <= 1'b0;
                m_tc   <= 1'b0;
                m_rem  <= half_len(sel);
            end else if (m_rem == 1) begin
                m_out <= ~m_out;
                m_tc  <= 1'b1;
                m_rem <= half_len(sel);
            end else begin
                m_tc  <= 1'b0;
                m_rem <= m_rem - 1;
            end
        end else begin
            m_tc <= 1'b0;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            check(sq === m_out, cur_req, "sq_o vs model", int'(sq), int'(m_out));
            check(tc === m_tc,  cur_req, "tc_o vs model", int'(tc), int'(m_tc));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            failures++;
            $display("FAIL watchdog %s actual=%0d expected=%0d", cur_req, cyc, 190000);
            finish_run();
        end
    end

    // Counts negedges until tc_o is seen.
    task automatic measure(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (tc !== 1'b1);
    endtask

    initial begin
        int n;
        int n2;
        bit held;

        // R1: reset state
        repeat (4) @(negedge clk);
        check(sq === 1'b0, "R1", "sq_o in reset", int'(sq), 0);
        check(tc === 1'b0, "R1", "tc_o in reset", int'(tc), 0);

        // R7: idle with enable low stays low
        cur_req = "R7";
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check(sq === 1'b0, "R7", "idle sq_o with enable low", int'(sq), 0);

        // R5: start-up half period from the enabling cycle
        cur_req = "R5";
        sel = 4'd9;
        en  = 1'b1;
        measure(n);
        check(n == half_len(4'd9) + 1, "R5", "first half incl. load cycle", n, half_len(4'd9) + 1);

        // R3: 100 Hz preset half period, both halves equal
        cur_req = "R3";
        measure(n);
        check(n == 5, "R3", "half period code 9", n, 5);
        measure(n2);
        check(n2 == n, "R3", "duty: second half", n2, n);

        // R6: change just after an edge; current half unchanged
        cur_req = "R6";
        sel = 4'd8;
        measure(n);
        check(n == 5, "R6", "half after mid-change", n, 5);
        measure(n);
        check(n == 10, "R6", "half with new code 8", n, 10);

        // R2: folded codes behave like code 9
        cur_req = "R2";
        sel = 4'd13;
        measure(n);
        measure(n);
        check(n == 5, "R2", "code 13 half period", n, 5);
        for (int s = 2; s <= 7; s++) begin
            sel = 4'(s);
            measure(n);
            measure(n);
            check(n == half_len(4'(s)), "R2", "preset half period", n, half_len(4'(s)));
        end
        check(half_len(4'd4) == 500, "R3", "code 4 split", half_len(4'd4), 500);

        // R7: chopped enable inside half periods
        cur_req = "R7";
        sel = 4'd7;
        for (int i = 0; i < 400; i++) begin
            en = ((i % 3) != 0) && ((i % 17) != 5);
            @(negedge clk);
        end
        en = 1'b0;
        held = sq;
        repeat (30) begin
            @(negedge clk);
            check(sq === held, "R7", "sq_o frozen", int'(sq), int'(held));
            check(tc === 1'b0, "R7", "tc_o low while frozen", int'(tc), 0);
        end
        en = 1'b1;

        // R3: two-stage presets
        cur_req = "R3";
        sel = 4'd1;
        measure(n);
        measure(n);
        check(n == 4982, "R3", "half period code 1", n, 4982);
        sel = 4'd0;
        measure(n);
        measure(n);
        check(n == 49982, "R3", "half period code 0", n, 49982);

        // R9: reset in mid half period
        cur_req = "R9";
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(sq === 1'b0, "R9", "sq_o after mid-run reset", int'(sq), 0);
        check(tc === 1'b0, "R9", "tc_o after mid-run reset", int'(tc), 0);
        @(negedge clk);
        rst_n = 1'b1;
        sel = 4'd9;
        cur_req = "R5";
        measure(n);
        check(n == half_len(4'd9) + 1, "R9", "restart half period", n, half_len(4'd9) + 1);
        repeat (4) @(negedge clk);

        finish_run();
    end

endmodule